// File: doc/BRIEF.md
# Host-to-Controller Command Mailbox

This block is the meeting point between a host processor and a power-management microcontroller. The host programs two pointer registers and up to four words of input data, then writes a command word. That write latches the command, sets a busy flag and offers the command to the microcontroller through a doorbell. The microcontroller takes the doorbell, reads the input words by index, deposits up to four result words in the output buffer and signals completion with an error flag and an 8-bit error code. The host learns of the result by polling the busy flag or through an interrupt line, if the command asked for one.

The host side is a plain 32-bit register port with combinational read data and single-cycle writes. The doorbell is a valid/ready stream. `db_valid` rises on the cycle after an accepted command write and holds, with `db_cmd`, `db_sptr` and `db_dptr` stable, until a cycle in which `db_ready` is high. The completion path is also valid/ready. `cpl_ready` is high only while a command is busy and its doorbell has already been taken, so the microcontroller may hold `cpl_valid` for as long as it likes and the result is taken on the first cycle both are high. Output-buffer writes from the microcontroller are never stalled.

Top module: `ipc_mailbox`

## Requirements
- R1: After reset, status reads 0, the command register reads 0, `db_valid` is 0 and `host_irq` is 0.
- R2: A host write to offset 0x00 while not busy stores the word, which reads back at 0x00. It sets status bit 0 (busy) and raises `db_valid` with `db_cmd` equal to the word. `db_valid` stays high and `db_cmd` stays stable until the cycle `db_ready` is high.
- R3: A host write to offset 0x00 while busy is ignored: the command readback is unchanged and no second doorbell is raised.
- R4: `cpl_ready` is 0 until the doorbell is taken. A completion accepted while busy clears busy in the same clock edge that loads status bit 1 with `cpl_err` and status bits 23:16 with `cpl_code`.
- R5: On completion, status bit 2 (interrupt pending) is set only when bit 8 of the latched command word is 1. `host_irq` always equals that bit.
- R6: A host write to status (offset 0x04) with bit 2 set clears the pending bit. A status write with bit 2 clear leaves it unchanged.
- R7: An accepted command write clears the previous error bit and error code.
- R8: Offsets 0x08 (source pointer) and 0x0C (destination pointer) are read/write, and their values appear on `db_sptr` and `db_dptr`.
- R9: Host writes to offsets 0x80, 0x84, 0x88 and 0x8C fill input words 0 to 3, and the microcontroller reads word n on `mc_ibuf_data` when `mc_ibuf_idx` is n.
- R10: Microcontroller writes to output word n are read by the host at offset 0x90 + 4n. Host writes to that region are ignored.
- R11: Reads of unmapped or misaligned (bits 1:0 not zero) offsets return 0, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hst_wr | input | 1 | Host write strobe |
| hst_addr | input | 8 | Host byte offset |
| hst_wdata | input | 32 | Host write data |
| hst_rdata | output | 32 | Host read data for `hst_addr` (combinational) |
| db_valid | output | 1 | Doorbell: command pending for the microcontroller |
| db_ready | input | 1 | Microcontroller takes the doorbell |
| db_cmd | output | 32 | Latched command word |
| db_sptr | output | 32 | Source pointer |
| db_dptr | output | 32 | Destination pointer |
| mc_ibuf_idx | input | 2 | Input-buffer word index for the microcontroller |
| mc_ibuf_data | output | 32 | Input-buffer word at `mc_ibuf_idx` |
| mc_obuf_we | input | 1 | Output-buffer write strobe |
| mc_obuf_idx | input | 2 | Output-buffer word index |
| mc_obuf_data | input | 32 | Output-buffer write data |
| cpl_valid | input | 1 | Completion offered |
| cpl_ready | output | 1 | Completion can be taken |
| cpl_err | input | 1 | Completion error flag |
| cpl_code | input | 8 | Completion error code |
| host_irq | output | 1 | Completion interrupt level to the host |

## Verification
The command path is run with two command words. One has bit 8 set and is completed with an error and a non-zero code. The other has bit 8 clear and is completed cleanly. Together they separate the interrupt gating from the busy and error updates, and show that the second command wipes the first one's error. A command write issued while busy, a completion offered before the doorbell is taken, status writes with and without bit 2, host writes into the output region, and unmapped or misaligned offsets each probe a case where state must not move. Distinct per-word patterns in both buffers expose swapped or aliased word indices.

// File: rtl/ipc_mbx_pkg.sv
package ipc_mbx_pkg;
  localparam int unsigned OFS_W = 12;

  localparam logic [OFS_W-1:0] OFS_CMD  = 12'h000;
  localparam logic [OFS_W-1:0] OFS_STS  = 12'h004;
  localparam logic [OFS_W-1:0] OFS_SPTR = 12'h008;
  localparam logic [OFS_W-1:0] OFS_DPTR = 12'h00C;
  localparam logic [OFS_W-1:0] OFS_IBUF = 12'h080;
  localparam logic [OFS_W-1:0] OFS_OBUF = 12'h090;

  localparam int unsigned CMD_IRQ_BIT  = 8;
  localparam int unsigned STS_BUSY_BIT = 0;
  localparam int unsigned STS_ERR_BIT  = 1;
  localparam int unsigned STS_IRQ_BIT  = 2;
  localparam int unsigned STS_CODE_LSB = 16;
  localparam int unsigned CODE_W       = 8;

  typedef struct packed {
    logic              busy;
    logic              err;
    logic              irq;
    logic [CODE_W-1:0] code;
  } mbx_state_t;

  function automatic logic [31:0] pack_status(mbx_state_t s);
    logic [31:0] v;
    v = '0;
    v[STS_BUSY_BIT] = s.busy;
    v[STS_ERR_BIT]  = s.err;
    v[STS_IRQ_BIT]  = s.irq;
    v[STS_CODE_LSB +: CODE_W] = s.code;
    return v;
  endfunction
endpackage

// File: rtl/ipc_mbx_ctrl.sv
module ipc_mbx_ctrl
  import ipc_mbx_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_we,
  input  logic              sts_we,
  input  logic [DW-1:0]     wdata,
  input  logic              db_ready,
  input  logic              cpl_valid,
  input  logic              cpl_err,
  input  logic [CODE_W-1:0] cpl_code,
  output logic [DW-1:0]     cmd_q,
  output logic              db_valid,
  output logic              cpl_ready,
  output mbx_state_t        state
);
  logic cmd_take;
  logic cpl_fire;

  assign cmd_take  = cmd_we && !state.busy;
  assign cpl_ready = state.busy && !db_valid;
  assign cpl_fire  = cpl_valid && cpl_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q      <= '0;
      db_valid   <= 1'b0;
      state.busy <= 1'b0;
      state.err  <= 1'b0;
      state.code <= '0;
    end else if (cmd_take) begin
      cmd_q      <= wdata;
      db_valid   <= 1'b1;
      state.busy <= 1'b1;
      state.err  <= 1'b0;
      state.code <= '0;
    end else begin
      if (db_valid && db_ready) db_valid <= 1'b0;
      if (cpl_fire) begin
        state.busy <= 1'b0;
        state.err  <= cpl_err;
        state.code <= cpl_code;
      end
    end
  end

  // Completion setting the pending bit wins over a same-cycle clear.
  always_ff @(posedge clk) begin
    if (!rst_n)                                state.irq <= 1'b0;
    else if (cpl_fire && cmd_q[CMD_IRQ_BIT])   state.irq <= 1'b1;
    else if (sts_we && wdata[STS_IRQ_BIT])     state.irq <= 1'b0;
  end

  AST_DB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    db_valid && !db_ready |=> db_valid && $stable(cmd_q)); // R2
  AST_BUSY_CMD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_we && state.busy |=> $stable(cmd_q)); // R3
  AST_DB_IMPLIES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    db_valid |-> state.busy); // R4
  AST_CPL_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    cpl_fire |=> !state.busy && state.err == $past(cpl_err) && state.code == $past(cpl_code)); // R4
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    cpl_fire && !cmd_q[CMD_IRQ_BIT] && !state.irq |=> !state.irq); // R5
  AST_NEW_CMD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_take |=> state.busy && !state.err && state.code == '0); // R7
endmodule

// File: rtl/ipc_mbx_wordbuf.sv
module ipc_mbx_wordbuf #(
  parameter int unsigned WORDS = 4,
  parameter int unsigned DW    = 32,
  parameter int unsigned IW    = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [IW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic [IW-1:0] rd_idx,
  output logic [DW-1:0] rd_data
);
  logic [DW-1:0] mem [WORDS];

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rst_n)                         mem[w] <= '0;
      else if (we && wr_idx == IW'(w))    mem[w] <= wr_data;
    end
  end

  assign rd_data = mem[rd_idx];

  AST_WORD_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> mem[$past(wr_idx)] == $past(wr_data)); // R9
endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox
  import ipc_mbx_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned DW        = 32,
  parameter int unsigned BUF_BYTES = 16,
  parameter int unsigned BUF_WORDS = BUF_BYTES / 4,
  parameter int unsigned IDX_W     = $clog2(BUF_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hst_wr,
  input  logic [ADDR_W-1:0] hst_addr,
  input  logic [DW-1:0]     hst_wdata,
  output logic [DW-1:0]     hst_rdata,
  output logic              db_valid,
  input  logic              db_ready,
  output logic [DW-1:0]     db_cmd,
  output logic [DW-1:0]     db_sptr,
  output logic [DW-1:0]     db_dptr,
  input  logic [IDX_W-1:0]  mc_ibuf_idx,
  output logic [DW-1:0]     mc_ibuf_data,
  input  logic              mc_obuf_we,
  input  logic [IDX_W-1:0]  mc_obuf_idx,
  input  logic [DW-1:0]     mc_obuf_data,
  input  logic              cpl_valid,
  output logic              cpl_ready,
  input  logic              cpl_err,
  input  logic [CODE_W-1:0] cpl_code,
  output logic              host_irq
);
  localparam int unsigned REG_LSB = 2;
  localparam int unsigned RGN_LSB = $clog2(BUF_BYTES);
  localparam logic [ADDR_W-1:0] A_CMD  = ADDR_W'(OFS_CMD);
  localparam logic [ADDR_W-1:0] A_STS  = ADDR_W'(OFS_STS);
  localparam logic [ADDR_W-1:0] A_SPTR = ADDR_W'(OFS_SPTR);
  localparam logic [ADDR_W-1:0] A_DPTR = ADDR_W'(OFS_DPTR);
  localparam logic [ADDR_W-1:0] A_IBUF = ADDR_W'(OFS_IBUF);
  localparam logic [ADDR_W-1:0] A_OBUF = ADDR_W'(OFS_OBUF);

  logic aligned, sel_cmd, sel_sts, sel_sptr, sel_dptr, sel_ibuf, sel_obuf;
  logic [IDX_W-1:0] hst_idx;
  logic [DW-1:0] sptr_q, dptr_q, obuf_rdata;
  mbx_state_t state;

  assign aligned  = hst_addr[REG_LSB-1:0] == '0;
  assign sel_cmd  = aligned && hst_addr == A_CMD;
  assign sel_sts  = aligned && hst_addr == A_STS;
  assign sel_sptr = aligned && hst_addr == A_SPTR;
  assign sel_dptr = aligned && hst_addr == A_DPTR;
  assign sel_ibuf = aligned && hst_addr[ADDR_W-1:RGN_LSB] == A_IBUF[ADDR_W-1:RGN_LSB];
  assign sel_obuf = aligned && hst_addr[ADDR_W-1:RGN_LSB] == A_OBUF[ADDR_W-1:RGN_LSB];
  assign hst_idx  = hst_addr[REG_LSB +: IDX_W];

  ipc_mbx_ctrl #(.DW(DW)) ctrl_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_we    (hst_wr && sel_cmd),
    .sts_we    (hst_wr && sel_sts),
    .wdata     (hst_wdata),
    .db_ready  (db_ready),
    .cpl_valid (cpl_valid),
    .cpl_err   (cpl_err),
    .cpl_code  (cpl_code),
    .cmd_q     (db_cmd),
    .db_valid  (db_valid),
    .cpl_ready (cpl_ready),
    .state     (state)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sptr_q <= '0;
      dptr_q <= '0;
    end else if (hst_wr) begin
      if (sel_sptr) sptr_q <= hst_wdata;
      if (sel_dptr) dptr_q <= hst_wdata;
    end
  end

  assign db_sptr  = sptr_q;
  assign db_dptr  = dptr_q;
  assign host_irq = state.irq;

  ipc_mbx_wordbuf #(.WORDS(BUF_WORDS), .DW(DW), .IW(IDX_W)) ibuf_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (hst_wr && sel_ibuf),
    .wr_idx  (hst_idx),
    .wr_data (hst_wdata),
    .rd_idx  (mc_ibuf_idx),
    .rd_data (mc_ibuf_data)
  );

  ipc_mbx_wordbuf #(.WORDS(BUF_WORDS), .DW(DW), .IW(IDX_W)) obuf_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (mc_obuf_we),
    .wr_idx  (mc_obuf_idx),
    .wr_data (mc_obuf_data),
    .rd_idx  (hst_idx),
    .rd_data (obuf_rdata)
  );

  always_comb begin
    hst_rdata = '0;
    if (sel_cmd)       hst_rdata = db_cmd;
    else if (sel_sts)  hst_rdata = DW'(pack_status(state));
    else if (sel_sptr) hst_rdata = sptr_q;
    else if (sel_dptr) hst_rdata = dptr_q;
    else if (sel_obuf) hst_rdata = obuf_rdata;
  end

  AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    host_irq == hst_rdata[STS_IRQ_BIT] || !sel_sts); // R5
  AST_PTR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    hst_wr && sel_sptr |=> db_sptr == $past(hst_wdata)); // R8
endmodule

// File: tb/ipc_mailbox_tb_top.sv
module ipc_mailbox_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hst_wr = 1'b0;
  logic [7:0]  hst_addr = '0;
  logic [31:0] hst_wdata = '0;
  logic [31:0] hst_rdata;
  logic        db_valid, db_ready = 1'b0;
  logic [31:0] db_cmd, db_sptr, db_dptr;
  logic [1:0]  mc_ibuf_idx = '0;
  logic [31:0] mc_ibuf_data;
  logic        mc_obuf_we = 1'b0;
  logic [1:0]  mc_obuf_idx = '0;
  logic [31:0] mc_obuf_data = '0;
  logic        cpl_valid = 1'b0, cpl_ready, cpl_err = 1'b0;
  logic [7:0]  cpl_code = '0;
  logic        host_irq;

  int n_run = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  ipc_mailbox dut_i (
    .clk(clk), .rst_n(rst_n), .hst_wr(hst_wr), .hst_addr(hst_addr),
    .hst_wdata(hst_wdata), .hst_rdata(hst_rdata), .db_valid(db_valid),
    .db_ready(db_ready), .db_cmd(db_cmd), .db_sptr(db_sptr), .db_dptr(db_dptr),
    .mc_ibuf_idx(mc_ibuf_idx), .mc_ibuf_data(mc_ibuf_data),
    .mc_obuf_we(mc_obuf_we), .mc_obuf_idx(mc_obuf_idx), .mc_obuf_data(mc_obuf_data),
    .cpl_valid(cpl_valid), .cpl_ready(cpl_ready), .cpl_err(cpl_err),
    .cpl_code(cpl_code), .host_irq(host_irq)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic host_write(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    hst_wr = 1'b1; hst_addr = a; hst_wdata = d;
    @(negedge clk);
    hst_wr = 1'b0;
  endtask

  task automatic host_read(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    hst_addr = a;
    #1 d = hst_rdata;
  endtask

  task automatic take_doorbell();
    @(negedge clk);
    db_ready = 1'b1;
    @(negedge clk);
    db_ready = 1'b0;
  endtask

  task automatic complete(logic e, logic [7:0] c);
    @(negedge clk);
    cpl_valid = 1'b1; cpl_err = e; cpl_code = c;
    @(negedge clk);
    cpl_valid = 1'b0; cpl_err = 1'b0; cpl_code = '0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    host_read(8'h04, v); chk("R1", "status after reset", v, 32'h0);
    host_read(8'h00, v); chk("R1", "command after reset", v, 32'h0);
    chk("R1", "db_valid after reset", {31'b0, db_valid}, 32'h0);
    chk("R1", "irq after reset", {31'b0, host_irq}, 32'h0);
  endtask

  task automatic t_pointers();
    logic [31:0] v;
    host_write(8'h08, 32'h1234_5678);
    host_write(8'h0C, 32'h9ABC_DEF0);
    host_read(8'h08, v); chk("R8", "sptr readback", v, 32'h1234_5678);
    host_read(8'h0C, v); chk("R8", "dptr readback", v, 32'h9ABC_DEF0);
    chk("R8", "db_sptr", db_sptr, 32'h1234_5678);
    chk("R8", "db_dptr", db_dptr, 32'h9ABC_DEF0);
  endtask

  task automatic t_inbuf();
    for (int i = 0; i < 4; i++) host_write(8'h80 + 8'(4 * i), 32'hA000_0000 + 32'(i * 17 + 3));
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      mc_ibuf_idx = 2'(i);
      #1 chk("R9", "input word", mc_ibuf_data, 32'hA000_0000 + 32'(i * 17 + 3));
    end
  endtask

  task automatic t_cmd_irq();
    logic [31:0] v;
    host_write(8'h00, 32'h0010_3105);
    host_read(8'h04, v); chk("R2", "busy after command", v, 32'h1);
    host_read(8'h00, v); chk("R2", "command readback", v, 32'h0010_3105);
    chk("R2", "db_valid raised", {31'b0, db_valid}, 32'h1);
    chk("R2", "db_cmd", db_cmd, 32'h0010_3105);
    repeat (3) @(negedge clk);
    chk("R2", "db_valid held", {31'b0, db_valid}, 32'h1);
    chk("R4", "cpl_ready before doorbell taken", {31'b0, cpl_ready}, 32'h0);
    take_doorbell();
    chk("R2", "db_valid dropped", {31'b0, db_valid}, 32'h0);
    host_write(8'h00, 32'hDEAD_0000);
    host_read(8'h00, v); chk("R3", "command kept while busy", v, 32'h0010_3105);
    chk("R3", "no new doorbell", {31'b0, db_valid}, 32'h0);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      mc_obuf_we = 1'b1; mc_obuf_idx = 2'(i); mc_obuf_data = 32'h5500_0000 + 32'(i * 7 + 1);
    end
    @(negedge clk); mc_obuf_we = 1'b0;
    complete(1'b1, 8'h5A);
    host_read(8'h04, v); chk("R4", "status after failed completion", v, 32'h005A_0006);
    chk("R5", "irq raised", {31'b0, host_irq}, 32'h1);
    for (int i = 0; i < 4; i++) begin
      host_read(8'h90 + 8'(4 * i), v);
      chk("R10", "output word", v, 32'h5500_0000 + 32'(i * 7 + 1));
    end
    host_write(8'h94, 32'hFFFF_FFFF);
    host_read(8'h94, v); chk("R10", "host write to output ignored", v, 32'h5500_0008);
    host_write(8'h04, 32'h0000_0003);
    chk("R6", "irq kept on write without bit 2", {31'b0, host_irq}, 32'h1);
    host_write(8'h04, 32'h0000_0004);
    chk("R6", "irq cleared by W1C", {31'b0, host_irq}, 32'h0);
    host_read(8'h04, v); chk("R6", "status after W1C", v, 32'h005A_0002);
  endtask

  task automatic t_cmd_poll();
    logic [31:0] v;
    host_write(8'h00, 32'h0004_2042);
    host_read(8'h04, v); chk("R7", "new command clears error", v, 32'h1);
    take_doorbell();
    complete(1'b0, 8'h00);
    host_read(8'h04, v); chk("R5", "polled completion, no irq", v, 32'h0);
    chk("R5", "irq line low", {31'b0, host_irq}, 32'h0);
  endtask

  task automatic t_unmapped();
    logic [31:0] v;
    host_write(8'h0A, 32'hFFFF_FFFF);
    host_read(8'h08, v); chk("R11", "misaligned write ignored", v, 32'h1234_5678);
    host_read(8'h0A, v); chk("R11", "misaligned read", v, 32'h0);
    host_read(8'h40, v); chk("R11", "unmapped read", v, 32'h0);
    host_read(8'h80, v); chk("R11", "input buffer not host readable", v, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_pointers();
    t_inbuf();
    t_cmd_irq();
    t_cmd_poll();
    t_unmapped();
    repeat (2) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule